// File: doc/BRIEF.md
# Programmable Prioritized Interrupt Selector

This block routes a set of event inputs onto sixteen prioritized interrupt lines for a processor core. Every event is identified by a 5-bit code, and the code's bit position on the `evt_in` bus is its number. Lines 0 and 1 come from dedicated inputs: a reset event and a non-maskable interrupt. Lines 2 and 3 are reserved and never become pending. Each of lines 4 to 15 takes its source from a 5-bit selector field. The selector fields sit in two 32-bit registers that software can read and write.

The four external pin events (codes 4 to 7) have a programmable polarity. The block detects a rising edge on each selected source and latches it into a pending bit. It masks the maskable lines with a per-line enable register and a global enable input. It then presents the number of the highest-priority presented line, together with a valid flag. The core clears a pending bit by returning the line number on the acknowledge port.

Register accesses use a single-cycle port. A write takes effect at the clock edge. A read returns data combinationally from the current address.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the register at offset 0x4 holds selector codes 4, 5, 6, 7, 8, 9 for lines 4 to 9. The register at offset 0x0 holds codes 3, 10, 11, 0, 1, 2 for lines 10 to 15. Both registers use fields at bits [4:0], [9:5], [14:10], [20:16], [25:21] and [30:26], with the lowest line in the lowest field. The polarity register (offset 0x8) and the enable register (offset 0xC) reset to zero, and no line is pending.
- R2: Only the selector fields, polarity bits [3:0] at 0x8 and enable bits [15:4] at 0xC are stored. All other bits, and all other addresses, read as zero, and writes to them have no effect.
- R3: Line 4+k becomes pending on a rising edge of `evt_in[code]`, where code is the value of its selector field. Codes 19 to 31 select no source.
- R4: A pending bit is set by a 0-to-1 change of its source, sampled at one clock edge and visible after that edge. A source held high does not set the bit again. A pending bit stays set until it is acknowledged.
- R5: An acknowledge with line number n clears only pending bit n, effective at the next clock edge. If a new edge on line n arrives in the same cycle, the bit stays set.
- R6: When polarity bit i is 1, event code 4+i is inverted before edge detection, so a falling input edge sets the pending bit.
- R7: Lines 4 to 15 are presented only while their enable bit and `gie` are both 1. A masked line keeps its pending bit and is presented as soon as it is unmasked.
- R8: Lines 0 and 1 are driven by `rst_evt` and `nmi_in` and ignore the enable bits and `gie`. Lines 2 and 3 are never pending.
- R9: `irq_valid` is 1 when any line is presented, and `irq_num` gives the lowest-numbered presented line. `irq_num` is 0 when no line is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | 32 | Event inputs indexed by event code |
| rst_evt | input | 1 | Source of line 0 |
| nmi_in | input | 1 | Source of line 1 |
| gie | input | 1 | Global enable for lines 4 to 15 |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Line number being acknowledged |
| irq_valid | output | 1 | A presented line exists |
| irq_num | output | 4 | Highest-priority presented line |

## Verification
Several kinds of internal fault are visible one cycle after the stimulus that exposes them. A selector field that is routed to the wrong line, or packed at the wrong bit offset, shows a wrong `irq_num` one clock after the event edge. It also shows a wrong word at `reg_rdata` as soon as the address is applied. A pending bit that fails to clear, or that is set again by a held level, keeps `irq_valid` high on the cycle after the acknowledge. A wrong mask or priority order shows on the output combinationally, as soon as `gie` or the enable bits change.

// File: rtl/irq_route_pkg.sv
// Shared constants and helpers for the interrupt selector.
// Assumes six selector fields per 32-bit register, with one spare bit at 15.
package irq_route_pkg;
    localparam int NUM_LINES   = 16;
    localparam int FIXED_LINES = 4;
    localparam int SEL_LINES   = NUM_LINES - FIXED_LINES;
    localparam int CODE_W      = 5;
    localparam int NUM_CODES   = 1 << CODE_W;
    localparam int MAX_CODE    = 18;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int EXT_PINS    = 4;
    localparam int EXT_BASE    = 4;
    localparam int FIELDS_PER_REG = 6;
    localparam int LINE_W      = $clog2(NUM_LINES);

    localparam logic [ADDR_W-1:0] OFS_HI  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_LO  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_POL = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_EN  = 4'hC;

    // Bit offset of field j inside a selector register.
    function automatic int field_lsb(input int j);
        return j * CODE_W + ((j >= 3) ? 1 : 0);
    endfunction

    // Reset selector code for maskable slot k (line k+4).
    function automatic logic [CODE_W-1:0] default_code(input int k);
        case (k)
            6:  return 5'd3;
            7:  return 5'd10;
            8:  return 5'd11;
            9:  return 5'd0;
            10: return 5'd1;
            11: return 5'd2;
            default: return CODE_W'(k + 4);
        endcase
    endfunction
endpackage

// File: rtl/irq_sel_regs.sv
// Register file: two selector registers, the pin polarity register and the
// line enable register. Assumes aligned byte offsets; reads are combinational.
module irq_sel_regs
    import irq_route_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic [SEL_LINES*CODE_W-1:0] sel_flat,
    output logic [EXT_PINS-1:0]         pol_q,
    output logic [NUM_LINES-1:0]        en_q
);
    logic [CODE_W-1:0]          sel_q [SEL_LINES];
    logic [NUM_LINES-1:0]       en_r;

    // Register writes, with reset defaults; unmapped bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SEL_LINES; k++) sel_q[k] <= default_code(k);
            pol_q <= '0;
            en_r  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_LO: for (int j = 0; j < FIELDS_PER_REG; j++)
                            sel_q[j] <= reg_wdata[field_lsb(j) +: CODE_W];
                OFS_HI: for (int j = 0; j < FIELDS_PER_REG; j++)
                            sel_q[FIELDS_PER_REG+j] <= reg_wdata[field_lsb(j) +: CODE_W];
                OFS_POL: pol_q <= reg_wdata[EXT_PINS-1:0];
                OFS_EN:  en_r  <= {reg_wdata[NUM_LINES-1:FIXED_LINES], {FIXED_LINES{1'b0}}};
                default: ;
            endcase
        end
    end

    // Read mux: packs fields back, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_LO: for (int j = 0; j < FIELDS_PER_REG; j++)
                        reg_rdata[field_lsb(j) +: CODE_W] = sel_q[j];
            OFS_HI: for (int j = 0; j < FIELDS_PER_REG; j++)
                        reg_rdata[field_lsb(j) +: CODE_W] = sel_q[FIELDS_PER_REG+j];
            OFS_POL: reg_rdata[EXT_PINS-1:0] = pol_q;
            OFS_EN:  reg_rdata[NUM_LINES-1:0] = en_r;
            default: ;
        endcase
    end

    assign en_q = en_r;

    for (genvar k = 0; k < SEL_LINES; k++) begin : g_flat
        assign sel_flat[k*CODE_W +: CODE_W] = sel_q[k];
    end

    // R2
    pol_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_POL) |-> (reg_rdata[DATA_W-1:EXT_PINS] == '0));
    // R2
    en_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_EN) |-> (reg_rdata[DATA_W-1:NUM_LINES] == '0 &&
                                  reg_rdata[FIXED_LINES-1:0] == '0));
endmodule

// File: rtl/irq_src_mux.sv
// Source selection: applies pin polarity, removes reserved codes, and picks
// each maskable line's event by its selector code. Purely combinational.
module irq_src_mux
    import irq_route_pkg::*;
(
    input  logic [NUM_CODES-1:0]        evt_in,
    input  logic [EXT_PINS-1:0]         pol_q,
    input  logic [SEL_LINES*CODE_W-1:0] sel_flat,
    input  logic                        rst_evt,
    input  logic                        nmi_in,
    output logic [NUM_LINES-1:0]        line_src
);
    logic [NUM_CODES-1:0] cond;

    // Conditioned event vector: polarity on pins, reserved codes zeroed.
    always_comb begin
        cond = evt_in;
        for (int i = 0; i < EXT_PINS; i++)
            cond[EXT_BASE+i] = evt_in[EXT_BASE+i] ^ pol_q[i];
        for (int c = MAX_CODE + 1; c < NUM_CODES; c++)
            cond[c] = 1'b0;
    end

    assign line_src[0] = rst_evt;
    assign line_src[1] = nmi_in;
    assign line_src[FIXED_LINES-1:2] = '0;

    for (genvar k = 0; k < SEL_LINES; k++) begin : g_pick
        assign line_src[FIXED_LINES+k] = cond[sel_flat[k*CODE_W +: CODE_W]];
    end
endmodule

// File: rtl/irq_pend_array.sv
// Edge detection and pending bits. A rising source edge sets a bit; an
// acknowledge clears one bit; a same-cycle edge wins over the clear.
module irq_pend_array
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_src,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_num,
    output logic [NUM_LINES-1:0] pend_q
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] edge_v;
    logic [NUM_LINES-1:0] clr_v;

    assign edge_v = line_src & ~prev_q;
    assign clr_v  = ack_valid ? (NUM_LINES'(1) << ack_num) : '0;

    // Source history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= line_src;
    end

    // Pending state update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_v) | edge_v;
    end

    // R4
    set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(edge_v)) == '0));
    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && !edge_v[ack_num] |=> !pend_q[$past(ack_num)]);
    // R8
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[FIXED_LINES-1:2] == '0);
endmodule

// File: rtl/irq_prio_enc.sv
// Masking and priority encoding: lines 0-1 always presented, 4-15 gated by
// per-line enables and the global enable; lowest number wins.
module irq_prio_enc
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_q,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic                 gie,
    output logic                 irq_valid,
    output logic [LINE_W-1:0]    irq_num
);
    logic [NUM_LINES-1:0] presented;

    // Presented set after masking.
    always_comb begin
        presented = pend_q & (en_q & {NUM_LINES{gie}});
        presented[1:0] = pend_q[1:0];
    end

    // Lowest-numbered presented line.
    always_comb begin
        irq_valid = 1'b0;
        irq_num   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (presented[i]) begin
                irq_valid = 1'b1;
                irq_num   = LINE_W'(i);
            end
        end
    end

    // R9
    winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> pend_q[irq_num]);
    // R9
    no_lower_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((pend_q & en_q & {NUM_LINES{gie}} & ((NUM_LINES'(1) << irq_num) - 1'b1)) == '0));
    // R7
    masked_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_num >= LINE_W'(FIXED_LINES)) |-> (gie && en_q[irq_num]));
endmodule

// File: rtl/irq_route_ctrl.sv
// Top of the interrupt selector: register file, source mux, pending array
// and priority encoder. Assumes all inputs synchronous to clk.
module irq_route_ctrl
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       evt_in,
    input  logic              rst_evt,
    input  logic              nmi_in,
    input  logic              gie,
    input  logic              ack_valid,
    input  logic [3:0]        ack_num,
    output logic              irq_valid,
    output logic [3:0]        irq_num
);
    logic [SEL_LINES*CODE_W-1:0] sel_flat;
    logic [EXT_PINS-1:0]         pol_q;
    logic [NUM_LINES-1:0]        en_q;
    logic [NUM_LINES-1:0]        line_src;
    logic [NUM_LINES-1:0]        pend_q;

    irq_sel_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel_flat(sel_flat),
        .pol_q(pol_q), .en_q(en_q)
    );

    irq_src_mux u_mux (
        .evt_in(evt_in), .pol_q(pol_q), .sel_flat(sel_flat),
        .rst_evt(rst_evt), .nmi_in(nmi_in), .line_src(line_src)
    );

    irq_pend_array u_pend (
        .clk(clk), .rst_n(rst_n), .line_src(line_src),
        .ack_valid(ack_valid), .ack_num(ack_num), .pend_q(pend_q)
    );

    irq_prio_enc u_prio (
        .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .en_q(en_q), .gie(gie),
        .irq_valid(irq_valid), .irq_num(irq_num)
    );

    // R3
    reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[CODE_W-1:0] > 5'd18) |-> !line_src[FIXED_LINES]);
endmodule

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_in = '0;
    logic        rst_evt = 1'b0, nmi_in = 1'b0, gie = 1'b0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic        irq_valid;
    logic [3:0]  irq_num;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .rst_evt(rst_evt), .nmi_in(nmi_in), .gie(gie), .ack_valid(ack_valid),
        .ack_num(ack_num), .irq_valid(irq_valid), .irq_num(irq_num)
    );

    typedef struct packed {
        logic [31:0] evt;
        logic [15:0] en;
        logic        g;
        logic        exp_v;
        logic [3:0]  exp_n;
    } vec_t;

    // Default routing: line4..9 <- 4..9, 10 <- 3, 11 <- 10, 12 <- 11, 13 <- 0, 14 <- 1, 15 <- 2
    localparam vec_t VECS [9] = '{
        '{32'h0000_0010, 16'hFFF0, 1'b1, 1'b1, 4'd4},   // R3 code 4 -> line 4
        '{32'h0000_0008, 16'hFFF0, 1'b1, 1'b1, 4'd10},  // R3 code 3 -> line 10
        '{32'h0000_0001, 16'hFFF0, 1'b1, 1'b1, 4'd13},  // R3 code 0 -> line 13
        '{32'h0000_0804, 16'hFFF0, 1'b1, 1'b1, 4'd12},  // R9 lines 12,15 -> 12
        '{32'h0000_0202, 16'hFFF0, 1'b1, 1'b1, 4'd9},   // R9 lines 9,14 -> 9
        '{32'h0010_0000, 16'hFFF0, 1'b1, 1'b0, 4'd0},   // R3 reserved code 20
        '{32'h0000_1000, 16'hFFF0, 1'b1, 1'b0, 4'd0},   // R3 unselected code 12
        '{32'h0000_0010, 16'hFFF0, 1'b0, 1'b0, 4'd0},   // R7 global enable off
        '{32'h0000_0120, 16'hFFC0, 1'b1, 1'b1, 4'd8}    // R7 line 5 disabled
    };

    function automatic logic [31:0] pack6(input int c0, c1, c2, c3, c4, c5);
        logic [31:0] w = '0;
        w[4:0] = 5'(c0); w[9:5] = 5'(c1); w[14:10] = 5'(c2);
        w[20:16] = 5'(c3); w[25:21] = 5'(c4); w[30:26] = 5'(c5);
        return w;
    endfunction

    task automatic chk_irq(input string tag, input logic ev, input logic [3:0] en_);
        n_run++;
        if (irq_valid !== ev || irq_num !== (ev ? en_ : 4'd0)) begin
            n_fail++;
            $display("FAIL %s: irq valid/num = %0b/%0d, expected %0b/%0d",
                     tag, irq_valid, irq_num, ev, ev ? en_ : 4'd0);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        n_run++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata@%0h = %h, expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ack(input int n);
        @(negedge clk);
        ack_valid = 1'b1; ack_num = 4'(n);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        evt_in = '0; rst_evt = 1'b0; nmi_in = 1'b0;
        for (int i = 0; i < 16; i++) ack(i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd("R1 high selectors", 4'h0, pack6(3, 10, 11, 0, 1, 2));
        chk_rd("R1 low selectors",  4'h4, pack6(4, 5, 6, 7, 8, 9));
        chk_rd("R1 polarity", 4'h8, 32'h0);
        chk_rd("R1 enables",  4'hC, 32'h0);
        chk_irq("R1 nothing pending", 1'b0, 4'd0);

        // R2 unused bits and addresses
        wr(4'h4, 32'hFFFF_FFFF);
        chk_rd("R2 low selector mask", 4'h4, 32'h7FFF_7FFF);
        wr(4'h4, pack6(4, 5, 6, 7, 8, 9));
        wr(4'hC, 32'hFFFF_FFFF);
        chk_rd("R2 enable mask", 4'hC, 32'h0000_FFF0);
        wr(4'h1, 32'hFFFF_FFFF);
        chk_rd("R2 unmapped offset", 4'h1, 32'h0);
        chk_rd("R2 unmapped write ignored", 4'h8, 32'h0);
        clear_all();

        // Vector table
        for (int v = 0; v < 9; v++) begin
            wr(4'hC, {16'h0, VECS[v].en});
            gie = VECS[v].g;
            pulse(VECS[v].evt);
            chk_irq($sformatf("R3/R7/R9 vector %0d", v), VECS[v].exp_v, VECS[v].exp_n);
            clear_all();
        end
        wr(4'hC, 32'h0000_FFF0);
        gie = 1'b1;

        // R3 reprogrammed selector, then a reserved code
        wr(4'h4, pack6(12, 5, 6, 7, 8, 9));
        pulse(32'h0000_1000);
        chk_irq("R3 line 4 from code 12", 1'b1, 4'd4);
        clear_all();
        wr(4'h4, pack6(19, 5, 6, 7, 8, 9));
        pulse(32'h0008_0000);
        chk_irq("R3 code 19 selects nothing", 1'b0, 4'd0);
        clear_all();
        wr(4'h4, pack6(4, 5, 6, 7, 8, 9));

        // R4 level does not retrigger; pending holds
        pulse(32'h0000_0040);
        @(negedge clk);
        chk_irq("R4 pending holds", 1'b1, 4'd6);
        ack(6);
        chk_irq("R4 held level no retrigger", 1'b0, 4'd0);
        clear_all();

        // R5 acknowledge clears only the named line; same-cycle edge wins
        pulse(32'h0000_00A0);
        chk_irq("R5 two pending", 1'b1, 4'd5);
        ack(5);
        chk_irq("R5 other line kept", 1'b1, 4'd7);
        ack(7);
        chk_irq("R5 all cleared", 1'b0, 4'd0);
        @(negedge clk);
        evt_in = 32'h0000_0100; ack_valid = 1'b1; ack_num = 4'd8;
        @(negedge clk);
        ack_valid = 1'b0;
        chk_irq("R5 edge beats ack", 1'b1, 4'd8);
        clear_all();

        // R6 polarity: enabling inversion on pin code 4 makes an idle-low pin active
        wr(4'h8, 32'h0000_0001);
        @(negedge clk);
        chk_irq("R6 inversion edge", 1'b1, 4'd4);
        ack(4);
        pulse(32'h0000_0010);
        chk_irq("R6 rising input is inactive", 1'b0, 4'd0);
        pulse(32'h0000_0000);
        chk_irq("R6 falling input sets", 1'b1, 4'd4);
        ack(4);
        wr(4'h8, 32'h0000_0000);
        clear_all();

        // R8 fixed lines ignore masks
        gie = 1'b0;
        wr(4'hC, 32'h0);
        @(negedge clk);
        rst_evt = 1'b1; nmi_in = 1'b1;
        @(negedge clk);
        chk_irq("R8 line 0 first", 1'b1, 4'd0);
        ack(0);
        chk_irq("R8 nmi unmaskable", 1'b1, 4'd1);
        ack(1);
        chk_irq("R8 cleared", 1'b0, 4'd0);
        clear_all();

        // R7 masked pending appears when unmasked
        wr(4'hC, 32'h0000_FFF0);
        pulse(32'h0000_0010);
        chk_irq("R7 masked by gie", 1'b0, 4'd0);
        @(negedge clk);
        gie = 1'b1;
        #0.5;
        chk_irq("R7 revealed by gie", 1'b1, 4'd4);
        clear_all();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule